// File: doc/BRIEF.md
# SECDED Hamming Word Decoder with Error Statistics

This block receives a message word and its parity word, which arrive on separate ports from a matching Hamming encoder. It returns the corrected message one clock later. The parity-check structure is derived from the message width when the design is elaborated. In its default form the block corrects any single flipped bit, using the Hamming syndrome together with one extra overall parity bit. It flags any double flip as uncorrectable and passes that word through untouched.

Two saturating counters record the events. One counts the errors that were corrected. The other counts the errors that were detected but could not be corrected. A clear input resets both counters. Parameters can turn correction off, drop the extra parity bit, or reduce the code to a single even-parity bit.

Top module: `hdec_top`

## Requirements
- R1: The code layout is as follows.
  - Codeword positions are numbered from 1, and power-of-two positions hold the Hamming parity bits.
  - Message bit i takes the i-th non-power-of-two position in ascending order.
  - Parity bit k (`par_i[k]`, for k below HP) is the XOR of the message bits whose position has bit k set.
  - HP is the smallest value with 2^HP >= MSG_W+HP+1.
  - When EXTRA_PAR=1, `par_i[HP]` makes the XOR of all message and parity bits zero.
- R2: A word with no error appears unchanged on `data_o` one cycle after it is applied, and neither counter moves.
- R3: With correction on, a word with one flipped bit in either the message or the parity gives back the original message on `data_o`.
- R4: Each corrected single error adds one to `cnt_fix_o` and leaves `cnt_det_o` unchanged.
- R5: With the extra bit present, a word with two flipped bits is passed through uncorrected and adds one to `cnt_det_o`, not to `cnt_fix_o`.
- R6: While `en` is low, `data_o` and both counters hold their values, whatever is applied on the inputs.
- R7: The counters stop at all ones instead of wrapping.
- R8: A high `cnt_clr` at a clock edge zeroes both counters. It takes priority over an increment at the same edge and acts whether or not `en` is high.
- R9: With CORRECT_EN=0, `data_o` carries the received message unchanged, and every non-clean word adds one to `cnt_det_o`.
- R10: With SINGLE_PAR=1, `par_i` is one bit holding the XOR of the message. A parity mismatch adds one to `cnt_det_o`, and even numbers of flips go unseen. The data always passes unchanged.
- R11: Reset has these properties.
  - Driving `rst_n` low clears `data_o` and both counters at once, without waiting for a clock edge.
  - Release is synchronised by two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output register and the counters |
| cnt_clr | input | 1 | Zeroes both counters |
| data_i | input | MSG_W | Received message |
| par_i | input | PAR_W | Received parity (HP+EXTRA_PAR bits, or 1 in single-bit mode) |
| data_o | output | MSG_W | Registered, corrected message |
| cnt_fix_o | output | CNT_W | Count of corrected errors |
| cnt_det_o | output | CNT_W | Count of detected, uncorrected errors |

## Verification
The bench builds three copies with an 8-bit message.

The first copy uses the default SECDED setup with 16-bit counters. It makes exhaustive sweeps possible: every message value, with no flip, with every single flip across all 13 codeword bits, and with every distinct pair of flips. It also checks the exact counter totals after each sweep.

The second copy has correction off and 4-bit counters, so the sweeps drive it to saturation.

The third copy uses single-parity mode and shows that odd flips are counted while even flips go unseen.

// File: rtl/hdec_pkg.sv
package hdec_pkg;

  function automatic int hp_count(int msg_w);
    for (int p = 1; p < 31; p++) begin
      if ((1 << p) >= msg_w + p + 1) return p;
    end
    return 31;
  endfunction

  // codeword position of message bit idx (non-power-of-two slots, ascending)
  function automatic int pos_of(int idx);
    int seen;
    seen = 0;
    for (int pos = 3; pos < 4096; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (seen == idx) return pos;
        seen++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/hdec_rst_sync.sv
module hdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/hdec_syn.sv
module hdec_syn #(
  parameter int MSG_W = 8,
  parameter int HP    = 4
) (
  input  logic [MSG_W-1:0] data_i,
  input  logic [HP-1:0]    par_h_i,
  output logic [HP-1:0]    syn_o
);
  import hdec_pkg::*;

  always_comb begin
    syn_o = par_h_i;
    for (int i = 0; i < MSG_W; i++) begin
      for (int k = 0; k < HP; k++) begin
        if (((pos_of(i) >> k) & 1) == 1) syn_o[k] = syn_o[k] ^ data_i[i];
      end
    end
  end
endmodule

// File: rtl/hdec_fix.sv
module hdec_fix #(
  parameter int MSG_W      = 8,
  parameter int HP         = 4,
  parameter bit CORRECT_EN = 1'b1,
  parameter bit EXTRA_PAR  = 1'b1
) (
  input  logic [MSG_W-1:0] data_i,
  input  logic [HP-1:0]    syn_i,
  input  logic             ov_i,
  output logic [MSG_W-1:0] data_o,
  output logic             ev_fix_o,
  output logic             ev_det_o
);
  import hdec_pkg::*;

  logic nz;
  assign nz = |syn_i;

  generate
    if (CORRECT_EN) begin : g_corr
      logic [MSG_W-1:0] hit;
      logic             single, dbl, loc_ok;

      always_comb begin
        for (int i = 0; i < MSG_W; i++) hit[i] = (syn_i == HP'(pos_of(i)));
      end

      assign single   = EXTRA_PAR ? ov_i : nz;
      assign dbl      = EXTRA_PAR & nz & ~ov_i;
      assign loc_ok   = (syn_i == '0) | $onehot(syn_i) | (|hit);
      assign ev_fix_o = single & loc_ok;
      assign ev_det_o = (single & ~loc_ok) | dbl;
      assign data_o   = single ? (data_i ^ hit) : data_i;
    end else begin : g_nocorr
      assign ev_fix_o = 1'b0;
      assign ev_det_o = nz | ov_i;
      assign data_o   = data_i;
    end
  endgenerate
endmodule

// File: rtl/hdec_satcnt.sv
module hdec_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)                    q_d = '0;
    else if (inc && q != CMAX)  q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q == CMAX && !clr) |=> (q == CMAX)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R8
  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (q >= $past(q))); // R4
endmodule

// File: rtl/hdec_top.sv
module hdec_top #(
  parameter int MSG_W      = 8,
  parameter bit CORRECT_EN = 1'b1,
  parameter bit EXTRA_PAR  = 1'b1,
  parameter bit SINGLE_PAR = 1'b0,
  parameter int CNT_W      = 16,
  localparam int HP        = SINGLE_PAR ? 1 : hdec_pkg::hp_count(MSG_W),
  localparam int PAR_W     = SINGLE_PAR ? 1 : HP + int'(EXTRA_PAR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cnt_clr,
  input  logic [MSG_W-1:0] data_i,
  input  logic [PAR_W-1:0] par_i,
  output logic [MSG_W-1:0] data_o,
  output logic [CNT_W-1:0] cnt_fix_o,
  output logic [CNT_W-1:0] cnt_det_o
);
  logic             rst_sync_n;
  logic [MSG_W-1:0] data_fix;
  logic             ev_fix, ev_det;
  logic [MSG_W-1:0] data_d;

  hdec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    if (SINGLE_PAR) begin : g_single
      assign ev_det   = ^{data_i, par_i};
      assign ev_fix   = 1'b0;
      assign data_fix = data_i;
    end else begin : g_ham
      logic [HP-1:0] syn;
      logic          ov;

      hdec_syn #(.MSG_W(MSG_W), .HP(HP)) u_syn (
        .data_i  (data_i),
        .par_h_i (par_i[HP-1:0]),
        .syn_o   (syn)
      );

      assign ov = EXTRA_PAR ? (^{data_i, par_i}) : 1'b0;

      hdec_fix #(
        .MSG_W(MSG_W), .HP(HP), .CORRECT_EN(CORRECT_EN), .EXTRA_PAR(EXTRA_PAR)
      ) u_fix (
        .data_i   (data_i),
        .syn_i    (syn),
        .ov_i     (ov),
        .data_o   (data_fix),
        .ev_fix_o (ev_fix),
        .ev_det_o (ev_det)
      );

      AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (en && syn == '0 && !ov) |=> (data_o == $past(data_i))); // R2
    end
  endgenerate

  always_comb begin
    data_d = data_o;
    if (en) data_d = data_fix;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) data_o <= '0;
    else             data_o <= data_d;
  end

  hdec_satcnt #(.W(CNT_W)) u_cnt_fix (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (cnt_clr),
    .inc   (en & ev_fix),
    .q     (cnt_fix_o)
  );

  hdec_satcnt #(.W(CNT_W)) u_cnt_det (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (cnt_clr),
    .inc   (en & ev_det),
    .q     (cnt_det_o)
  );

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ev_fix && ev_det)); // R4
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable(data_o)); // R6
  AST_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en && !cnt_clr) |=> ($stable(cnt_fix_o) && $stable(cnt_det_o))); // R6
endmodule

// File: tb/sim_hdec_top.sv
`timescale 1ns/1ps
module sim_hdec_top;
  localparam int MW = 8;
  localparam int NB = 13; // 8 message + 4 Hamming + 1 extra

  logic clk, rst_n, en, clr;
  logic [MW-1:0] d0, d2;
  logic [4:0]    p0;
  logic [0:0]    p2;
  logic [MW-1:0] q0, q1, q2;
  logic [15:0]   f0, e0, f2, e2;
  logic [3:0]    f1, e1;

  int nvec, nerr;
  int exp_e2;

  hdec_top u0 (.clk(clk), .rst_n(rst_n), .en(en), .cnt_clr(clr), .data_i(d0),
               .par_i(p0), .data_o(q0), .cnt_fix_o(f0), .cnt_det_o(e0));
  hdec_top #(.CORRECT_EN(1'b0), .CNT_W(4)) u1 (.clk(clk), .rst_n(rst_n), .en(en),
               .cnt_clr(clr), .data_i(d0), .par_i(p0), .data_o(q1),
               .cnt_fix_o(f1), .cnt_det_o(e1));
  hdec_top #(.SINGLE_PAR(1'b1)) u2 (.clk(clk), .rst_n(rst_n), .en(en), .cnt_clr(clr),
               .data_i(d2), .par_i(p2), .data_o(q2), .cnt_fix_o(f2), .cnt_det_o(e2));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [4:0] enc(logic [MW-1:0] v);
    logic [4:0] p;
    int pos, bi;
    p = '0;
    bi = 0;
    for (int n = 1; n <= 12; n++) begin
      if ((n & (n - 1)) != 0) begin
        for (int k = 0; k < 4; k++) if ((n >> k) & 1) p[k] = p[k] ^ v[bi];
        bi++;
      end
    end
    pos = 0;
    p[4] = ^{v, p[3:0]};
    return p;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [12:0] w;
    logic [8:0]  w2;
    nvec = 0; nerr = 0; exp_e2 = 0;
    rst_n = 1'b0; en = 1'b1; clr = 1'b0;
    d0 = '0; p0 = '0; d2 = '0; p2 = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset data", q0, 0);
    chk("R11 reset fix", f0, 0);
    chk("R11 reset det", e0, 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // R2: clean words, R1 encoding
    for (int v = 0; v < 256; v++) begin
      d0 = MW'(v); p0 = enc(MW'(v)); d2 = MW'(v); p2 = ^MW'(v);
      tick();
      chk("R2 clean u0", q0, v);
      chk("R9 clean u1", q1, v);
      chk("R10 clean u2", q2, v);
    end
    chk("R2 fix count", f0, 0);
    chk("R2 det count", e0, 0);
    chk("R10 clean det", e2, 0);

    // R3/R4: every single flip
    for (int v = 0; v < 256; v++) begin
      for (int b = 0; b < NB; b++) begin
        w = {enc(MW'(v)), MW'(v)} ^ (13'd1 << b);
        d0 = w[7:0]; p0 = w[12:8];
        w2 = {^MW'(v), MW'(v)};
        if (b < 9) begin w2 = w2 ^ (9'd1 << b); exp_e2++; end
        d2 = w2[7:0]; p2 = w2[8];
        tick();
        chk("R3 single fix", q0, v);
        chk("R9 no correction", q1, w[7:0]);
        chk("R10 single passthrough", q2, w2[7:0]);
      end
    end
    chk("R4 fix count", f0, 256 * NB);
    chk("R4 det unchanged", e0, 0);
    chk("R7 saturated det", e1, 15);
    chk("R9 fix stays zero", f1, 0);
    chk("R10 odd flips counted", e2, exp_e2);

    // R5: every double flip
    for (int v = 0; v < 256; v++) begin
      for (int a = 0; a < NB; a++) begin
        for (int b = a + 1; b < NB; b++) begin
          w = {enc(MW'(v)), MW'(v)} ^ (13'd1 << a) ^ (13'd1 << b);
          d0 = w[7:0]; p0 = w[12:8];
          w2 = {^MW'(v), MW'(v)};
          if (b < 9) w2 = w2 ^ (9'd1 << a) ^ (9'd1 << b);
          d2 = w2[7:0]; p2 = w2[8];
          tick();
          chk("R5 double passthrough", q0, w[7:0]);
          chk("R10 double passthrough", q2, w2[7:0]);
        end
      end
    end
    chk("R5 det count", e0, 256 * 78);
    chk("R5 fix unchanged", f0, 256 * NB);
    chk("R10 even flips unseen", e2, exp_e2);

    // R6: enable low holds everything
    d0 = 8'h5A; p0 = enc(8'h5A);
    tick();
    en = 1'b0;
    d0 = 8'h5A ^ 8'h10; p0 = enc(8'h5A);
    tick(); tick();
    chk("R6 data held", q0, 8'h5A);
    chk("R6 fix held", f0, 256 * NB);
    chk("R6 det held", e0, 256 * 78);
    en = 1'b1;
    tick();
    chk("R6 resumes", q0, 8'h5A);
    chk("R6 resumes count", f0, 256 * NB + 1);

    // R8: clear beats a same-cycle increment
    clr = 1'b1;
    tick();
    clr = 1'b0;
    chk("R8 clear fix", f0, 0);
    chk("R8 clear det", e0, 0);
    chk("R8 clear u1", e1, 0);
    tick();
    chk("R8 count after clear", f0, 1);
    en = 1'b0; clr = 1'b1;
    tick();
    clr = 1'b0; en = 1'b1;
    chk("R8 clear with en low", f0, 0);

    // R11: asynchronous reset
    d0 = 8'hC3; p0 = enc(8'hC3);
    tick();
    chk("R11 pre-reset", q0, 8'hC3);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R11 async data", q0, 0);
    chk("R11 async fix", f0, 0);
    rst_n = 1'b1;
    tick();
    chk("R11 held during sync", q0, 0);
    tick(); tick();
    chk("R11 running again", q0, 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule